// File: doc/BRIEF.md
# Extended Error Log Dump Sequencer

This block gathers first-failure diagnostic state from one hardware unit after an error. It drives a single-outstanding 64-bit register bus to collect the data and emits each register value it reads as a record of (address, index, value) on a valid/ready stream. Software starts it with a one-cycle pulse and a unit base offset. The block then works unattended until it raises a one-cycle done pulse.

The collection has two phases. The first phase reads an error-log pointer. When that pointer is present, the block walks a list of 64-bit descriptor words. Each descriptor requests one of two things: a burst of repeated reads of a single register, or a sweep over a contiguous register region. The second phase visits a fixed set of diagnostic rings. For every ring that is populated, the block writes a selector register once per trace and then drains a mailbox register as many times as the ring map dictates.

Top module: `errlog_dump_seq`

## Requirements
- R1: If the pointer read from `unit_off | PTR_OFFS` is 0 or all-ones, the block fetches no descriptor or data register and goes straight to the ring scan.
- R2: Descriptor words are read from `unit_off | pointer[31:0]`, then from addresses 8 apart. Within a descriptor, bits 23:0 give the target (ORed with `unit_off`), bits 38:24 give a length and bit 39 gives the mode. A descriptor word of 0 or all-ones ends the list.
- R3: When the mode bit is 1, the target address is read `length` times. Record k carries that address, index k and the read data.
- R4: When the mode bit is 0, the length is in bytes. The block makes floor(length/8) reads at target, target+8, and so on, all with index 0. A length below 8 produces no reads.
- R5: Ring maps are read for rings 0 through NUM_RINGS-1 in ascending order, from `unit_off | (MAP_OFFS + 8*ring)`. In a map, bits 31:24 hold the trap count, bits 23:16 the highest trace number, and bits 15:0 the entries per trace. A map of 0 or all-ones skips its ring.
- R6: For each trace t from 0 up to and including the highest trace number, the block first writes the selector value (ring << 8) | t to `unit_off | SEL_OFFS`, which is the only address it ever writes. It then reads the mailbox trap-count times when t = 0, or entries-per-trace times when t > 0.
- R7: Each mailbox record carries address `unit_off | MBOX_OFFS`, index (selector << 16) | entry number, and the read data.
- R8: While a bus request waits for its acknowledge, its address, direction and write data stay stable. No second access is issued, and no access is in flight while a record is pending.
- R9: A record stays valid and unchanged until `rec_ready`. Records are never dropped or reordered.
- R10: `done` is a one-cycle pulse that comes after the last ring has been handled and after the final record has been accepted. A `start` pulse that arrives while a dump is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a dump when idle |
| unit_off | input | ADDR_W | Unit base offset ORed into every address |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register byte address |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | Access completes in a cycle with `bus_req` high |
| bus_rdata | input | 64 | Read data, valid with `bus_ack` |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_addr | output | ADDR_W | Record register address |
| rec_idx | output | 32 | Record index |
| rec_val | output | 64 | Record value |
| done | output | 1 | One-cycle completion pulse |

## Verification
There are two points where one cycle does two jobs. The first is the acceptance of the final mailbox record, which is also the cycle in which the block decides that the scan has ended. The second is the cycle in which a bus acknowledge loads a new record. The bench provokes both by placing populated rings last, including the highest ring, while throttling `rec_ready` at random and varying the acknowledge latency. It judges the result by requiring every expected record to be consumed before the single done pulse is seen, and by requiring exactly one done per dump, even when a second start pulse is injected mid-dump.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
    localparam int WORD_W = 64;
    localparam int IDX_W  = 32;
    localparam int LEN_W  = 15;
    localparam int CNT_W  = 16;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PTR, ST_DESC, ST_DATA, ST_DATA_OUT,
        ST_MAP, ST_SEL, ST_MBOX, ST_MBOX_OUT
    } seq_st_e;

    function automatic logic word_absent(input logic [WORD_W-1:0] w);
        return (w == '0) || (&w);
    endfunction
endpackage

// File: rtl/errlog_field_dec.sv
module errlog_field_dec
    import errlog_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [WORD_W-1:0] word,
    input  logic [ADDR_W-1:0] unit,
    output logic              absent,
    output logic [ADDR_W-1:0] d_addr,
    output logic              d_rep,
    output logic [CNT_W-1:0]  d_cnt,
    output logic [7:0]        m_traps,
    output logic [7:0]        m_traces,
    output logic [15:0]       m_ents
);
    logic [LEN_W-1:0] len;

    always_comb begin
        absent   = word_absent(word);
        len      = word[38:24];
        d_rep    = word[39];
        d_addr   = unit | ADDR_W'(word[23:0]);
        // repeat mode counts reads, region mode counts bytes
        d_cnt    = d_rep ? CNT_W'(len) : CNT_W'(len >> 3);
        m_traps  = word[31:24];
        m_traces = word[23:16];
        m_ents   = word[15:0];
    end
endmodule

// File: rtl/errlog_bus_mst.sv
module errlog_bus_mst
    import errlog_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              resp,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_ack
);
    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } port_t;

    port_t port_d, port_q;

    always_comb begin
        port_d = port_q;
        if (!port_q.req && cmd_valid) begin
            port_d.req   = 1'b1;
            port_d.we    = cmd_we;
            port_d.addr  = cmd_addr;
            port_d.wdata = cmd_wdata;
        end else if (port_q.req && bus_ack) begin
            port_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    assign resp      = port_q.req && bus_ack;
    assign bus_req   = port_q.req;
    assign bus_we    = port_q.we;
    assign bus_addr  = port_q.addr;
    assign bus_wdata = port_q.wdata;

    // R8: a pending access keeps its attributes until acknowledged
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
endmodule

// File: rtl/errlog_dump_seq.sv
module errlog_dump_seq
    import errlog_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                NUM_RINGS = 8,
    parameter logic [ADDR_W-1:0] PTR_OFFS  = ADDR_W'('h40),
    parameter logic [ADDR_W-1:0] MAP_OFFS  = ADDR_W'('h80),
    parameter logic [ADDR_W-1:0] SEL_OFFS  = ADDR_W'('hC0),
    parameter logic [ADDR_W-1:0] MBOX_OFFS = ADDR_W'('hC8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] unit_off,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [IDX_W-1:0]  rec_idx,
    output logic [WORD_W-1:0] rec_val,
    output logic              done
);
    localparam int RING_W   = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1;
    localparam int STEP_SH  = 3;
    localparam logic [RING_W-1:0] LAST_RING = RING_W'(NUM_RINGS - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] unit;
        logic [ADDR_W-1:0] lptr;
        logic [ADDR_W-1:0] daddr;
        logic              rep;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  iter;
        logic [RING_W-1:0] ring;
        logic [7:0]        traps;
        logic [7:0]        traces;
        logic [7:0]        trace;
        logic [15:0]       ents;
        logic              rec_v;
        logic [ADDR_W-1:0] rec_a;
        logic [IDX_W-1:0]  rec_i;
        logic [WORD_W-1:0] rec_d;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              cmd_valid, cmd_we, resp;
    logic [ADDR_W-1:0] cmd_addr;
    logic [WORD_W-1:0] cmd_wdata;

    logic              w_absent, w_rep;
    logic [ADDR_W-1:0] w_addr;
    logic [CNT_W-1:0]  w_cnt;
    logic [7:0]        w_traps, w_traces;
    logic [15:0]       w_ents;

    logic [CNT_W-1:0]  next_iter, sel_cnt;
    logic [15:0]       sel_val;
    logic              ring_last, trace_last;

    errlog_bus_mst #(.ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .resp(resp),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack)
    );

    errlog_field_dec #(.ADDR_W(ADDR_W)) u_dec (
        .word(bus_rdata), .unit(seq_q.unit),
        .absent(w_absent), .d_addr(w_addr), .d_rep(w_rep), .d_cnt(w_cnt),
        .m_traps(w_traps), .m_traces(w_traces), .m_ents(w_ents)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        cmd_valid  = 1'b0;
        cmd_we     = 1'b0;
        cmd_addr   = '0;
        cmd_wdata  = '0;
        next_iter  = seq_q.iter + CNT_W'(1);
        ring_last  = (seq_q.ring == LAST_RING);
        trace_last = (seq_q.trace == seq_q.traces);
        sel_val    = {8'(seq_q.ring), seq_q.trace};
        sel_cnt    = (seq_q.trace == 8'd0) ? CNT_W'(seq_q.traps) : CNT_W'(seq_q.ents);

        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.unit = unit_off;
                    seq_d.st   = ST_PTR;
                end
            end
            ST_PTR: begin
                cmd_valid = 1'b1;
                cmd_addr  = seq_q.unit | PTR_OFFS;
                if (resp) begin
                    if (w_absent) begin
                        seq_d.ring = '0;
                        seq_d.st   = ST_MAP;
                    end else begin
                        seq_d.lptr = seq_q.unit | bus_rdata[ADDR_W-1:0];
                        seq_d.st   = ST_DESC;
                    end
                end
            end
            ST_DESC: begin
                cmd_valid = 1'b1;
                cmd_addr  = seq_q.lptr;
                if (resp) begin
                    if (w_absent) begin
                        seq_d.ring = '0;
                        seq_d.st   = ST_MAP;
                    end else begin
                        seq_d.daddr = w_addr;
                        seq_d.rep   = w_rep;
                        seq_d.cnt   = w_cnt;
                        seq_d.iter  = '0;
                        seq_d.lptr  = seq_q.lptr + ADDR_W'(8);
                        seq_d.st    = (w_cnt == '0) ? ST_DESC : ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                cmd_valid = 1'b1;
                cmd_addr  = seq_q.daddr;
                if (resp) begin
                    seq_d.rec_v = 1'b1;
                    seq_d.rec_a = seq_q.daddr;
                    seq_d.rec_i = seq_q.rep ? IDX_W'(seq_q.iter) : '0;
                    seq_d.rec_d = bus_rdata;
                    seq_d.st    = ST_DATA_OUT;
                end
            end
            ST_DATA_OUT: begin
                if (rec_ready) begin
                    seq_d.rec_v = 1'b0;
                    seq_d.iter  = next_iter;
                    if (!seq_q.rep) seq_d.daddr = seq_q.daddr + ADDR_W'(8);
                    seq_d.st    = (next_iter == seq_q.cnt) ? ST_DESC : ST_DATA;
                end
            end
            ST_MAP: begin
                cmd_valid = 1'b1;
                cmd_addr  = seq_q.unit | (MAP_OFFS + (ADDR_W'(seq_q.ring) << STEP_SH));
                if (resp) begin
                    if (w_absent) begin
                        if (ring_last) begin
                            seq_d.done = 1'b1;
                            seq_d.st   = ST_IDLE;
                        end else begin
                            seq_d.ring = seq_q.ring + RING_W'(1);
                        end
                    end else begin
                        seq_d.traps  = w_traps;
                        seq_d.traces = w_traces;
                        seq_d.ents   = w_ents;
                        seq_d.trace  = 8'd0;
                        seq_d.st     = ST_SEL;
                    end
                end
            end
            ST_SEL: begin
                cmd_valid = 1'b1;
                cmd_we    = 1'b1;
                cmd_addr  = seq_q.unit | SEL_OFFS;
                cmd_wdata = WORD_W'(sel_val);
                if (resp) begin
                    seq_d.cnt  = sel_cnt;
                    seq_d.iter = '0;
                    if (sel_cnt != '0) begin
                        seq_d.st = ST_MBOX;
                    end else if (!trace_last) begin
                        seq_d.trace = seq_q.trace + 8'd1;
                    end else if (ring_last) begin
                        seq_d.done = 1'b1;
                        seq_d.st   = ST_IDLE;
                    end else begin
                        seq_d.ring = seq_q.ring + RING_W'(1);
                        seq_d.st   = ST_MAP;
                    end
                end
            end
            ST_MBOX: begin
                cmd_valid = 1'b1;
                cmd_addr  = seq_q.unit | MBOX_OFFS;
                if (resp) begin
                    seq_d.rec_v = 1'b1;
                    seq_d.rec_a = seq_q.unit | MBOX_OFFS;
                    seq_d.rec_i = {sel_val, seq_q.iter[15:0]};
                    seq_d.rec_d = bus_rdata;
                    seq_d.st    = ST_MBOX_OUT;
                end
            end
            ST_MBOX_OUT: begin
                if (rec_ready) begin
                    seq_d.rec_v = 1'b0;
                    seq_d.iter  = next_iter;
                    if (next_iter != seq_q.cnt) begin
                        seq_d.st = ST_MBOX;
                    end else if (!trace_last) begin
                        seq_d.trace = seq_q.trace + 8'd1;
                        seq_d.st    = ST_SEL;
                    end else if (ring_last) begin
                        seq_d.done = 1'b1;
                        seq_d.st   = ST_IDLE;
                    end else begin
                        seq_d.ring = seq_q.ring + RING_W'(1);
                        seq_d.st   = ST_MAP;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign rec_valid = seq_q.rec_v;
    assign rec_addr  = seq_q.rec_a;
    assign rec_idx   = seq_q.rec_i;
    assign rec_val   = seq_q.rec_d;
    assign done      = seq_q.done;

    // R9: a stalled record is held unchanged
    p_rec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_addr) && $stable(rec_idx) && $stable(rec_val));
    // R8: the bus is quiet while a record waits for the consumer
    p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> !bus_req);
    // R6: the selector register is the only write target
    p_wr_sel_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |-> bus_addr == (seq_q.unit | SEL_OFFS));
    // R10: completion is a single-cycle pulse with nothing outstanding
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req && !rec_valid);
    // R10: a start during a dump leaves the captured unit offset alone
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE) && start |=> $stable(seq_q.unit));
endmodule

// File: tb/errlog_dump_seq_tb.sv
`timescale 1ns/1ps
module errlog_dump_seq_tb;
    localparam logic [31:0] UNIT  = 32'h0300_0000;
    localparam logic [31:0] PTR_O = 32'h40;
    localparam logic [31:0] MAP_O = 32'h80;
    localparam logic [31:0] SEL_O = 32'hC0;
    localparam logic [31:0] MB_O  = 32'hC8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        bus_req, bus_we, bus_ack = 1'b0;
    logic [31:0] bus_addr;
    logic [63:0] bus_wdata, bus_rdata = '0;
    logic        rec_valid, rec_ready = 1'b1, done;
    logic [31:0] rec_addr, rec_idx;
    logic [63:0] rec_val;

    always #10 clk = ~clk;

    errlog_dump_seq #(
        .ADDR_W(32), .NUM_RINGS(8),
        .PTR_OFFS(PTR_O), .MAP_OFFS(MAP_O), .SEL_OFFS(SEL_O), .MBOX_OFFS(MB_O)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .unit_off(UNIT),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_addr(rec_addr), .rec_idx(rec_idx), .rec_val(rec_val), .done(done)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    int done_cnt, other_rd, bad_wr, r8_bad;
    bit slow = 0, stall = 0;
    int wait_cnt = 0;
    logic [15:0] sel_reg = '0;
    logic [31:0] mb_cnt = '0;
    logic        prev_pend = 1'b0;
    logic [31:0] prev_addr = '0;

    logic [63:0] cfg_ptr;
    logic [63:0] cfg_desc [8];
    int          ndesc;
    logic [63:0] cfg_map [8];

    logic [31:0] eq_addr[$];
    logic [31:0] eq_idx[$];
    logic [63:0] eq_val[$];
    string       eq_tag[$];

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] plain(input logic [31:0] a);
        return {a, a ^ 32'h5A5A_0F0F};
    endfunction

    function automatic bit absent(input logic [63:0] w);
        return (w == 64'h0) || (w == '1);
    endfunction

    function automatic logic [63:0] mk_desc(input bit rep, input int len, input logic [23:0] a);
        return {24'h0, rep, 15'(len), a};
    endfunction

    function automatic logic [63:0] mk_map(input int tp, input int tc, input int en);
        return {32'h0, 8'(tp), 8'(tc), 16'(en)};
    endfunction

    // register file model: responds one or more cycles after a request
    always @(negedge clk) begin
        bus_ack = 1'b0;
        if (rst_n && bus_req) begin
            if (prev_pend && bus_addr !== prev_addr) r8_bad++;
            if (wait_cnt != 0) begin
                wait_cnt--;
                prev_pend = 1'b1;
                prev_addr = bus_addr;
            end else begin
                bus_ack = 1'b1;
                prev_pend = 1'b0;
                if (bus_we) begin
                    if (bus_addr != (UNIT | SEL_O)) bad_wr++;
                    sel_reg = bus_wdata[15:0];
                end else if (bus_addr == (UNIT | PTR_O)) begin
                    bus_rdata = cfg_ptr;
                end else if (bus_addr >= (UNIT | MAP_O) && bus_addr < ((UNIT | MAP_O) + 32'd64)) begin
                    bus_rdata = cfg_map[int'((bus_addr - (UNIT | MAP_O)) >> 3)];
                end else if (bus_addr == (UNIT | MB_O)) begin
                    bus_rdata = {16'hA5A5, sel_reg, mb_cnt};
                    mb_cnt++;
                end else begin
                    logic [31:0] lb;
                    other_rd++;
                    lb = UNIT | cfg_ptr[31:0];
                    if (bus_addr >= lb && bus_addr < lb + 32'(8 * ndesc))
                        bus_rdata = cfg_desc[int'((bus_addr - lb) >> 3)];
                    else
                        bus_rdata = plain(bus_addr);
                end
                wait_cnt = slow ? int'($urandom_range(0, 2)) : 0;
            end
        end else begin
            prev_pend = 1'b0;
        end
    end

    // record consumer and done monitor (R9, R10)
    always @(negedge clk) begin
        rec_ready = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
        if (rst_n && rec_valid && rec_ready) begin
            if (eq_addr.size() == 0) begin
                chk("R9", "unexpected record addr", {32'h0, rec_addr}, 64'hFFFF_FFFF);
            end else begin
                string t;
                t = eq_tag.pop_front();
                chk(t, "record addr/index", {rec_addr, rec_idx}, {eq_addr.pop_front(), eq_idx.pop_front()});
                chk(t, "record value", rec_val, eq_val.pop_front());
            end
        end
        if (rst_n && done) begin
            done_cnt++;
            chk("R10", "records left at done", 64'(eq_addr.size()), 64'd0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_err++;
            $display("FAIL R10 watchdog expired: actual=%0d expected=<190000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    task automatic push(input logic [31:0] a, input logic [31:0] i, input logic [63:0] v, input string t);
        eq_addr.push_back(a); eq_idx.push_back(i); eq_val.push_back(v); eq_tag.push_back(t);
    endtask

    // expected record stream, derived from R1..R7
    task automatic build_exp();
        int mc = 0;
        eq_addr.delete(); eq_idx.delete(); eq_val.delete(); eq_tag.delete();
        if (!absent(cfg_ptr)) begin
            for (int k = 0; k < ndesc; k++) begin
                logic [63:0] w;
                logic [31:0] a;
                int len;
                w = cfg_desc[k];
                if (absent(w)) break;
                a   = UNIT | {8'h0, w[23:0]};
                len = int'(w[38:24]);
                if (w[39]) begin
                    for (int i = 0; i < len; i++) push(a, 32'(i), plain(a), "R2,R3");
                end else begin
                    for (int i = 0; i < len / 8; i++) push(a + 32'(8 * i), 32'h0, plain(a + 32'(8 * i)), "R2,R4");
                end
            end
        end
        for (int r = 0; r < 8; r++) begin
            logic [63:0] m;
            m = cfg_map[r];
            if (absent(m)) continue;
            for (int t = 0; t <= int'(m[23:16]); t++) begin
                logic [15:0] sel;
                int n;
                sel = 16'((r << 8) | t);
                n   = (t == 0) ? int'(m[31:24]) : int'(m[15:0]);
                for (int e = 0; e < n; e++) begin
                    push(UNIT | MB_O, {sel, 16'(e)}, {16'hA5A5, sel, 32'(mc)}, "R5,R6,R7");
                    mc++;
                end
            end
        end
    endtask

    task automatic clear_cfg();
        cfg_ptr = 64'h0;
        ndesc = 0;
        for (int k = 0; k < 8; k++) begin
            cfg_desc[k] = 64'h0;
            cfg_map[k]  = 64'h0;
        end
    endtask

    task automatic run_case(input string name, input bit second_start);
        int t = 0;
        done_cnt = 0; other_rd = 0; bad_wr = 0; r8_bad = 0; mb_cnt = '0;
        build_exp();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (done_cnt == 0 && t < 20000) begin
            @(negedge clk);
            t++;
            start = (second_start && t == 15);
        end
        start = 1'b0;
        repeat (8) @(negedge clk);
        chk("R10", {name, " done pulses"}, 64'(done_cnt), 64'd1);
        chk("R9", {name, " undelivered records"}, 64'(eq_addr.size()), 64'd0);
        chk("R6", {name, " writes off selector"}, 64'(bad_wr), 64'd0);
        chk("R8", {name, " request changed while pending"}, 64'(r8_bad), 64'd0);
    endtask

    initial begin
        clear_cfg();
        repeat (3) @(negedge clk);
        chk("R9", "reset rec_valid", 64'(rec_valid), 64'd0);
        chk("R8", "reset bus_req", 64'(bus_req), 64'd0);
        chk("R10", "reset done", 64'(done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: null pointer, only an all-ones map, no records at all
        clear_cfg();
        cfg_map[7] = '1;
        run_case("null-ptr", 1'b0);
        chk("R1", "null-ptr stray reads", 64'(other_rd), 64'd0);

        // R1, R5..R7: all-ones pointer with one populated ring
        clear_cfg();
        cfg_ptr = '1;
        cfg_map[0] = '1;
        cfg_map[2] = mk_map(2, 1, 3);
        slow = 1;
        run_case("ones-ptr", 1'b0);
        chk("R1", "ones-ptr stray reads", 64'(other_rd), 64'd0);

        // R2..R4, R10: mixed list, zero-count trace, last ring skipped, stall, extra start
        clear_cfg();
        cfg_ptr = 64'h1000;
        cfg_desc[0] = mk_desc(1'b1, 3, 24'h2000);
        cfg_desc[1] = mk_desc(1'b0, 20, 24'h3000);
        cfg_desc[2] = mk_desc(1'b1, 0, 24'h4000);
        cfg_desc[3] = mk_desc(1'b0, 7, 24'h5000);
        cfg_desc[4] = '1;
        ndesc = 5;
        cfg_map[0] = mk_map(0, 0, 5);
        cfg_map[5] = mk_map(1, 2, 1);
        cfg_map[7] = '1;
        stall = 1;
        run_case("mixed-list", 1'b1);

        // sweep trap/trace/entry counts, with records on the highest ring (R3, R4, R6, R10)
        for (int tp = 0; tp < 3; tp++) begin
            for (int tc = 0; tc < 3; tc++) begin
                for (int en = 0; en < 3; en++) begin
                    clear_cfg();
                    cfg_ptr = 64'h1000;
                    cfg_desc[0] = mk_desc(1'b1, tp + 1, 24'h2000);
                    cfg_desc[1] = mk_desc(1'b0, 8 * en + 5, 24'h6000);
                    cfg_desc[2] = 64'h0;
                    ndesc = 3;
                    cfg_map[3] = mk_map(tp, tc, en);
                    cfg_map[7] = mk_map(1, 0, 0);
                    slow  = ((tp + tc + en) % 2) == 1;
                    stall = (en % 2) == 0;
                    run_case($sformatf("sweep-%0d-%0d-%0d", tp, tc, en), 1'b0);
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule